// File: doc/BRIEF.md
# Slot-Keyed Interrupt Router

This block takes interrupt-pin events from devices sitting in fixed bus slots and folds them onto a 32-line internal interrupt space, then drives one interrupt wire toward the processor. Every event carries the slot it came from, the pin (0 to 3) that moved and the pin's new level. A fixed slot table gives the internal line. Two 32-bit configuration words, taken from the register file, set the behaviour of each line. One word chooses between pulse mode and level mode. The other gives the polarity that level mode uses.

Several source ports can present events in the same cycle. Each port has one holding entry. On each cycle, the held entry with the lowest slot number is served. The router reports the internal line, its global interrupt number (the line plus 32) and whether the slot had a mapping at all. It also updates the processor interrupt wire. Every output comes from a register.

Top module: `irq_slot_router`

## Requirements
- R1: After reset, `cpu_irq` and `out_vld` are low.
- R2: An event from slot 5 with pin n is reported on internal line n.
- R3: Any pin of slot 6 is reported on line 4. Any pin of slot 7 is reported on line 5.
- R4: Slots 8 to 12 with pin n are reported on line (slot − 8 + n) + 6.
- R5: For a mapped event, `out_gsi` equals the line number plus 32 and `out_unmapped` is 0.
- R6: When `edge_sel[line]` is 1, a mapped event drives `cpu_irq` high for exactly one cycle. After that cycle `cpu_irq` returns to the stored level value, which the event leaves unchanged.
- R7: When `edge_sel[line]` is 0, a mapped event stores a new level value and drives it onto `cpu_irq`. The value is the event level when `pol[line]` is 1 and the inverted event level when `pol[line]` is 0. It holds until the next mapped event.
- R8: An event from any other slot is reported with `out_unmapped` = 1, `out_line` = 0 and `out_gsi` equal to the pin number. `cpu_irq` keeps the stored level value.
- R9: Of the events waiting in the same cycle, the one with the lower slot number is reported first and the other one in the following cycle. When the slots are equal, the lower port index goes first.
- R10: An event sampled at one rising edge appears at the outputs after the second rising edge. `out_vld` is high for one cycle per event.
- R11: A new event offered on a port whose held event is not served in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_vld | input | NPORT | Per-port event strobe |
| ev_slot | input | NPORT*5 | Per-port source slot, port 0 in the low bits |
| ev_pin | input | NPORT*2 | Per-port pin number 0..3 |
| ev_level | input | NPORT | Per-port new pin level |
| edge_sel | input | 32 | Per-line mode select: 1 pulse, 0 level |
| pol | input | 32 | Per-line polarity used in level mode |
| out_vld | output | 1 | One-cycle strobe for a routed event |
| out_line | output | 5 | Internal line number |
| out_gsi | output | 6 | Global interrupt number, or the raw pin when unmapped |
| out_unmapped | output | 1 | The slot has no table entry |
| cpu_irq | output | 1 | Interrupt wire to the processor |

## Verification
A corrupted holding entry or a bad grant shows up two edges after the event. The symptom is a line number or global number that differs from the slot arithmetic, or events that leave in the wrong slot order. A stored level value that is wrong does not show immediately. It shows at the edge after any pulse-mode event, or after any unmapped event, because `cpu_irq` falls back to that value there. For that reason the sweep checks `cpu_irq` both in the cycle the event appears and in the cycle after it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SLOT_W        = 5;
  localparam int PIN_W         = 2;
  localparam int LINES         = 32;
  localparam int LINE_W        = $clog2(LINES);
  localparam int GSI_W         = LINE_W + 1;
  localparam int GSI_BASE      = LINES;
  localparam int SLOT_SHARED   = 5;
  localparam int SLOT_SOLO_A   = 6;
  localparam int SLOT_SOLO_B   = 7;
  localparam int SLOT_GRP_LO   = 8;
  localparam int SLOT_GRP_HI   = 12;
  localparam int LINE_SOLO_A   = 4;
  localparam int LINE_SOLO_B   = 5;
  localparam int LINE_GRP_BASE = 6;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [PIN_W-1:0]  pin;
    logic              level;
  } irq_evt_t;
endpackage

// File: rtl/irq_route_xlate.sv
module irq_route_xlate
  import irq_route_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic              mapped,
  output logic [LINE_W-1:0] line
);
  always_comb begin
    mapped = 1'b1;
    line   = '0;
    if (slot == SLOT_W'(SLOT_SHARED)) begin
      line = LINE_W'(pin);
    end else if (slot == SLOT_W'(SLOT_SOLO_A)) begin
      line = LINE_W'(LINE_SOLO_A);
    end else if (slot == SLOT_W'(SLOT_SOLO_B)) begin
      line = LINE_W'(LINE_SOLO_B);
    end else if (slot >= SLOT_W'(SLOT_GRP_LO) && slot <= SLOT_W'(SLOT_GRP_HI)) begin
      line = LINE_W'(slot) - LINE_W'(SLOT_GRP_LO) + LINE_W'(pin) + LINE_W'(LINE_GRP_BASE);
    end else begin
      mapped = 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
  import irq_route_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      in_vld,
  input  irq_evt_t [NPORT-1:0]  in_evt,
  output logic                  win_vld,
  output irq_evt_t              win_evt
);
  localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic     [NPORT-1:0] pend_v;
  irq_evt_t [NPORT-1:0] pend_e;
  logic     [NPORT-1:0] grant;
  logic     [IDX_W-1:0] best;
  logic                 found;

  always_comb begin
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (pend_v[i] && (!found || pend_e[i].slot < pend_e[best].slot)) begin
        best  = IDX_W'(i);
        found = 1'b1;
      end
    end
    grant = '0;
    if (found) grant[best] = 1'b1;
  end

  assign win_vld = found;
  assign win_evt = pend_e[best];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic     load;
    logic     v_d;
    irq_evt_t e_d;

    always_comb begin
      load = in_vld[g] && (!pend_v[g] || grant[g]);
      v_d  = load || (pend_v[g] && !grant[g]);
      e_d  = load ? in_evt[g] : pend_e[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_v[g] <= 1'b0;
        pend_e[g] <= '0;
      end else begin
        pend_v[g] <= v_d;
        pend_e[g] <= e_d;
      end
    end

    p_hold_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v[g] && !grant[g]) |=> (pend_v[g] && $stable(pend_e[g])));
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/irq_route_drive.sv
module irq_route_drive
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_vld,
  input  logic              win_mapped,
  input  logic [LINE_W-1:0] win_line,
  input  logic [PIN_W-1:0]  win_pin,
  input  logic              win_level,
  input  logic [LINES-1:0]  edge_sel,
  input  logic [LINES-1:0]  pol,
  output logic              out_vld,
  output logic [LINE_W-1:0] out_line,
  output logic [GSI_W-1:0]  out_gsi,
  output logic              out_unmapped,
  output logic              cpu_irq
);
  logic              lvl_q, lvl_d, cpu_d, vld_d, unm_d;
  logic [LINE_W-1:0] line_d;
  logic [GSI_W-1:0]  gsi_d;

  always_comb begin
    vld_d  = win_vld;
    line_d = '0;
    gsi_d  = '0;
    unm_d  = 1'b0;
    lvl_d  = lvl_q;
    cpu_d  = lvl_q;
    if (win_vld) begin
      if (win_mapped) begin
        line_d = win_line;
        gsi_d  = GSI_W'(GSI_BASE) + GSI_W'(win_line);
        if (edge_sel[win_line]) begin
          cpu_d = 1'b1;
        end else begin
          lvl_d = pol[win_line] ? win_level : ~win_level;
          cpu_d = lvl_d;
        end
      end else begin
        unm_d = 1'b1;
        gsi_d = GSI_W'(win_pin);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld      <= 1'b0;
      out_line     <= '0;
      out_gsi      <= '0;
      out_unmapped <= 1'b0;
      cpu_irq      <= 1'b0;
      lvl_q        <= 1'b0;
    end else begin
      out_vld      <= vld_d;
      out_line     <= line_d;
      out_gsi      <= gsi_d;
      out_unmapped <= unm_d;
      cpu_irq      <= cpu_d;
      lvl_q        <= lvl_d;
    end
  end

  p_line_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_unmapped) |-> (out_line <= LINE_W'(SLOT_GRP_HI - SLOT_GRP_LO + 3 + LINE_GRP_BASE)));

  p_unmapped_gsi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_unmapped) |-> (out_gsi < GSI_W'(1 << PIN_W) && out_line == '0));

  p_pulse_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_vld) |=> (cpu_irq == lvl_q));
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irq_route_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       ev_vld,
  input  logic [NPORT*SLOT_W-1:0] ev_slot,
  input  logic [NPORT*PIN_W-1:0] ev_pin,
  input  logic [NPORT-1:0]       ev_level,
  input  logic [LINES-1:0]       edge_sel,
  input  logic [LINES-1:0]       pol,
  output logic                   out_vld,
  output logic [LINE_W-1:0]      out_line,
  output logic [GSI_W-1:0]       out_gsi,
  output logic                   out_unmapped,
  output logic                   cpu_irq
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_evt_t [NPORT-1:0] in_evt;
  for (genvar g = 0; g < NPORT; g++) begin : g_unpack
    assign in_evt[g].slot  = ev_slot[g*SLOT_W +: SLOT_W];
    assign in_evt[g].pin   = ev_pin[g*PIN_W +: PIN_W];
    assign in_evt[g].level = ev_level[g];
  end

  logic              win_vld;
  irq_evt_t          win_evt;
  logic              win_mapped;
  logic [LINE_W-1:0] win_line;

  irq_route_arb #(.NPORT(NPORT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .in_vld  (ev_vld),
    .in_evt  (in_evt),
    .win_vld (win_vld),
    .win_evt (win_evt)
  );

  irq_route_xlate u_xlate (
    .slot   (win_evt.slot),
    .pin    (win_evt.pin),
    .mapped (win_mapped),
    .line   (win_line)
  );

  irq_route_drive u_drive (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .win_vld      (win_vld),
    .win_mapped   (win_mapped),
    .win_line     (win_line),
    .win_pin      (win_evt.pin),
    .win_level    (win_evt.level),
    .edge_sel     (edge_sel),
    .pol          (pol),
    .out_vld      (out_vld),
    .out_line     (out_line),
    .out_gsi      (out_gsi),
    .out_unmapped (out_unmapped),
    .cpu_irq      (cpu_irq)
  );

  p_gsi_offset_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_vld && !out_unmapped) |-> (out_gsi >= GSI_W'(GSI_BASE)));
endmodule

// File: tb/irq_slot_router_bench.sv
module irq_slot_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] ev_vld;
  logic [NP*5-1:0] ev_slot;
  logic [NP*2-1:0] ev_pin;
  logic [NP-1:0] ev_level;
  logic [31:0]   edge_sel, pol;
  logic          out_vld, out_unmapped, cpu_irq;
  logic [4:0]    out_line;
  logic [5:0]    out_gsi;

  int n_cmp = 0;
  int n_bad = 0;
  logic lvl_model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_slot_router #(.NPORT(NP)) u_irq_slot_router (
    .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_slot(ev_slot),
    .ev_pin(ev_pin), .ev_level(ev_level), .edge_sel(edge_sel), .pol(pol),
    .out_vld(out_vld), .out_line(out_line), .out_gsi(out_gsi),
    .out_unmapped(out_unmapped), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_line(input int s, input int p, output bit m);
    m = 1'b1;
    if (s == 5) return p;
    if (s == 6) return 4;
    if (s == 7) return 5;
    if (s >= 8 && s <= 12) return s - 8 + p + 6;
    m = 1'b0;
    return 0;
  endfunction

  task automatic put(input int port, input int s, input int p, input bit lv);
    ev_vld[port]           = 1'b1;
    ev_slot[port*5 +: 5]   = 5'(s);
    ev_pin[port*2 +: 2]    = 2'(p);
    ev_level[port]         = lv;
  endtask

  task automatic idle();
    ev_vld = '0; ev_slot = '0; ev_pin = '0; ev_level = '0;
  endtask

  task automatic expect_line(input string req, input int line);
    check({req, " vld"}, int'(out_vld), 1);
    check({req, " line"}, int'(out_line), line);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    edge_sel = '0;
    pol = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cpu_irq", int'(cpu_irq), 0);
    check("R1 out_vld", int'(out_vld), 0);

    // R2 R3 R4 R5 R6 R7 R8 R10: sweep every slot and pin
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        int it;
        int line;
        bit m;
        bit lv;
        bit exp_cpu;
        bit is_edge;
        it = s * 4 + p;
        edge_sel = ({32'h5A3C_96E1, 32'h5A3C_96E1} >> (it % 32));
        pol      = ({32'hC3A5_1F08, 32'hC3A5_1F08} >> ((it * 7) % 32));
        lv = it[0] ^ it[3];
        line = ref_line(s, p, m);
        put(it % NP, s, p, lv);
        @(negedge clk);
        idle();
        check("R10 early vld", int'(out_vld), 0);
        @(negedge clk);
        check("R10 vld", int'(out_vld), 1);
        is_edge = 1'b0;
        if (m) begin
          if (s == 5) check("R2 line", int'(out_line), line);
          else if (s == 6 || s == 7) check("R3 line", int'(out_line), line);
          else check("R4 line", int'(out_line), line);
          check("R5 gsi", int'(out_gsi), line + 32);
          check("R5 unmapped", int'(out_unmapped), 0);
          if (edge_sel[line]) begin
            is_edge = 1'b1;
            exp_cpu = 1'b1;
          end else begin
            lvl_model = pol[line] ? lv : ~lv;
            exp_cpu = lvl_model;
          end
          check(is_edge ? "R6 pulse" : "R7 level", int'(cpu_irq), int'(exp_cpu));
        end else begin
          check("R8 unmapped", int'(out_unmapped), 1);
          check("R8 line", int'(out_line), 0);
          check("R8 gsi", int'(out_gsi), p);
          check("R8 cpu_irq", int'(cpu_irq), int'(lvl_model));
        end
        @(negedge clk);
        check("R10 one cycle", int'(out_vld), 0);
        check(is_edge ? "R6 restore" : "R7 hold", int'(cpu_irq), int'(lvl_model));
      end
    end

    // R9: lower slot first
    edge_sel = '0;
    pol = '1;
    put(0, 9, 1, 1'b1);
    put(1, 6, 2, 1'b1);
    @(negedge clk); idle();
    @(negedge clk); expect_line("R9 first", 4);
    @(negedge clk); expect_line("R9 second", 8);
    @(negedge clk); check("R9 drained", int'(out_vld), 0);

    // R9: equal slots, lower port first
    put(0, 10, 0, 1'b1);
    put(1, 10, 3, 1'b1);
    @(negedge clk); idle();
    @(negedge clk); expect_line("R9 tie port0", 8);
    @(negedge clk); expect_line("R9 tie port1", 11);
    @(negedge clk); check("R9 tie drained", int'(out_vld), 0);

    // R11: port 0 still held, new offer dropped
    put(0, 12, 2, 1'b1);
    put(1, 7, 0, 1'b1);
    @(negedge clk);
    idle();
    put(0, 5, 1, 1'b1);
    @(negedge clk); idle();
    expect_line("R11 winner", 5);
    @(negedge clk); expect_line("R11 held", 12);
    @(negedge clk); check("R11 dropped", int'(out_vld), 0);
    @(negedge clk); check("R11 dropped late", int'(out_vld), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule